// File: doc/BRIEF.md
# Serial Character Transmitter with Modem Flow Control

This block turns bytes into asynchronous serial frames on a single output line. A one-entry holding register accepts a byte from the host side; when the shifter is free, the byte moves into it and is sent as one start bit, the data bits least significant first, and one stop bit. Bit timing comes from a baud tick at sixteen times the bit rate.

Flow control works in both directions. On the receive side, an optional mode holds each new character back until the clear-to-send input, after synchronization, is asserted. On the send side, the request-to-send output is driven by commands. An optional mode drops it automatically one bit-time after the last character of a message, provided the transmitter was told to disable.

A single command port carries enable, disable, break on, break off, and request-to-send set and clear. A break drives the line low whatever the state of clear-to-send.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset, txd is high, rts is low (negated), tx_rdy is high and the transmitter is disabled: a written byte is held and not sent until an enable command.
- R2: Each character is a frame made of a low start bit, then 8 data bits least significant bit first, then a high stop bit. Every bit lasts 16 baud_tick pulses.
- R3: tx_rdy is high exactly while the holding register is empty. A write while tx_rdy is high makes tx_rdy low on the next cycle, until the byte moves into the shifter. A write while tx_rdy is low is ignored.
- R4: A command is applied when cmd_valid is high, with cmd_op decoded as 1 enable, 2 disable, 3 break on, 4 break off, 5 rts set, 6 rts clear, and 0 or 7 meaning no operation.
- R5: With mode_cts_gate high, a character starts only while the synchronized cts is high. cts is looked at only when a character starts, so a character in progress always completes. With mode_cts_gate low, cts has no effect.
- R6: Break on holds txd low from the next character boundary and ignores cts. After break off, txd stays high for at least 16 baud ticks before the next start bit.
- R7: A disable command takes effect only after the character being shifted and any byte in the holding register have been sent. Later writes are then held and not sent.
- R8: rts rises only on an rts set command and falls only on an rts clear command or through the automatic negation of R9.
- R9: With mode_auto_rts high, a character whose stop bit ends while a disable is pending and the holding register is empty negates rts 16 baud ticks after that stop bit ends, and leaves the transmitter disabled. Sending again needs an rts set and an enable command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x bit rate |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R4) |
| mode_cts_gate | input | 1 | Gate each character start on cts |
| mode_auto_rts | input | 1 | Negate rts automatically after a message |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| cts | input | 1 | Clear to send, active high, asynchronous |
| txd | output | 1 | Serial output, idle high |
| rts | output | 1 | Request to send, active high |
| tx_rdy | output | 1 | Holding register empty |

## Verification
Frames are tried with alternating bits, all zeros, all ones and a mixed byte, sent back to back. This separates bit order, stuck data and a stop bit missing between frames. The cts line is tried held low, raised later, dropped in the middle of a character, and low with gating off; these cases separate gating at the start of a character from gating inside one, and from no gating at all. Disable is tried with one byte shifting and one held, and the automatic rts drop is timed on both sides of its one-bit delay. Break is tried with cts low, and the gap after it is measured before a queued byte goes out.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_BREAK, ST_GAP, ST_RTSW
    } tx_state_e;

    localparam logic [2:0] OP_EN      = 3'd1;
    localparam logic [2:0] OP_DIS     = 3'd2;
    localparam logic [2:0] OP_BRK_ON  = 3'd3;
    localparam logic [2:0] OP_BRK_OFF = 3'd4;
    localparam logic [2:0] OP_RTS_SET = 3'd5;
    localparam logic [2:0] OP_RTS_CLR = 3'd6;
endpackage

// File: rtl/uart_tx_sync.sv
module uart_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/uart_tx_bittimer.sv
module uart_tx_bittimer #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic bit_done
);
    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign bit_done = tick && !clr && (cnt_q == LAST);
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
    import uart_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              mode_cts_gate,
    input  logic              mode_auto_rts,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cts,
    output logic              txd,
    output logic              rts,
    output logic              tx_rdy
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    typedef struct packed {
        tx_state_e         st;
        logic              en;
        logic              dis_pend;
        logic              brk;
        logic              rts;
        logic              hold_full;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] shreg;
        logic [BW-1:0]     bidx;
    } tx_regs_t;

    localparam tx_regs_t RESET_VAL = '{
        st: ST_IDLE, en: 1'b0, dis_pend: 1'b0, brk: 1'b0, rts: 1'b0,
        hold_full: 1'b0, hold: '0, shreg: '0, bidx: '0
    };

    tx_regs_t cur_q, nxt_d;
    logic     cts_s;
    logic     bit_done;
    logic     timer_clr;
    logic     idle_w;
    logic     brk_w;

    uart_tx_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cts),
        .q     (cts_s)
    );

    assign timer_clr = (cur_q.st == ST_IDLE) || (cur_q.st == ST_BREAK);

    uart_tx_bittimer #(.OVS(OVS)) u_bit_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (timer_clr),
        .tick     (baud_tick),
        .bit_done (bit_done)
    );

    always_comb begin
        nxt_d = cur_q;

        // host write into the holding register
        if (wr_valid && !cur_q.hold_full) begin
            nxt_d.hold      = wr_data;
            nxt_d.hold_full = 1'b1;
        end

        unique case (cur_q.st)
            ST_IDLE: begin
                if (cur_q.brk) begin
                    nxt_d.st = ST_BREAK;
                end else if (cur_q.en && cur_q.hold_full &&
                             (!mode_cts_gate || cts_s)) begin
                    nxt_d.st        = ST_START;
                    nxt_d.shreg     = cur_q.hold;
                    nxt_d.hold_full = 1'b0;
                end else if (cur_q.dis_pend && !cur_q.hold_full) begin
                    nxt_d.en       = 1'b0;
                    nxt_d.dis_pend = 1'b0;
                end
            end
            ST_START: begin
                if (bit_done) begin
                    nxt_d.st   = ST_DATA;
                    nxt_d.bidx = '0;
                end
            end
            ST_DATA: begin
                if (bit_done) begin
                    nxt_d.shreg = cur_q.shreg >> 1;
                    if (cur_q.bidx == LAST_BIT) nxt_d.st = ST_STOP;
                    else                        nxt_d.bidx = cur_q.bidx + 1'b1;
                end
            end
            ST_STOP: begin
                if (bit_done) begin
                    if (mode_auto_rts && cur_q.dis_pend && !cur_q.hold_full)
                        nxt_d.st = ST_RTSW;
                    else
                        nxt_d.st = ST_IDLE;
                end
            end
            ST_BREAK: begin
                if (!cur_q.brk) nxt_d.st = ST_GAP;
            end
            ST_GAP: begin
                if (bit_done) nxt_d.st = ST_IDLE;
            end
            ST_RTSW: begin
                if (bit_done) begin
                    nxt_d.st       = ST_IDLE;
                    nxt_d.rts      = 1'b0;
                    nxt_d.en       = 1'b0;
                    nxt_d.dis_pend = 1'b0;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase

        // commands are applied last so they win over state-driven updates
        if (cmd_valid) begin
            case (cmd_op)
                OP_EN: begin
                    nxt_d.en       = 1'b1;
                    nxt_d.dis_pend = 1'b0;
                end
                OP_DIS:     if (cur_q.en) nxt_d.dis_pend = 1'b1;
                OP_BRK_ON:  nxt_d.brk = 1'b1;
                OP_BRK_OFF: nxt_d.brk = 1'b0;
                OP_RTS_SET: nxt_d.rts = 1'b1;
                OP_RTS_CLR: nxt_d.rts = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= RESET_VAL;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        unique case (cur_q.st)
            ST_START, ST_BREAK: txd = 1'b0;
            ST_DATA:            txd = cur_q.shreg[0];
            default:            txd = 1'b1;
        endcase
    end

    assign rts    = cur_q.rts;
    assign tx_rdy = !cur_q.hold_full;
    assign idle_w = (cur_q.st == ST_IDLE);
    assign brk_w  = cur_q.brk;
endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk
    import uart_tx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       txd,
    input logic       rts,
    input logic       tx_rdy,
    input logic       wr_valid,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       mode_cts_gate,
    input logic       mode_auto_rts,
    input logic       cts_s,
    input logic       idle_w,
    input logic       brk_w
);
    // R3: an accepted write fills the holding register on the next cycle
    p_write_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && tx_rdy) |=> !tx_rdy);

    // R3: ready only falls because of a write
    p_rdy_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_rdy) |-> $past(wr_valid));

    // R8: rts rises only on a set command
    p_rts_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts) |-> $past(cmd_valid && cmd_op == OP_RTS_SET));

    // R8 and R9: rts falls only on a clear command or in automatic mode
    p_rts_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts) |-> ($past(cmd_valid && cmd_op == OP_RTS_CLR) || $past(mode_auto_rts)));

    // R5: with gating on, a start bit leaving idle needs synchronized cts
    p_cts_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(txd) && $past(idle_w) && $past(mode_cts_gate) && !$past(brk_w))
        |-> $past(cts_s));
endmodule

bind uart_tx_flow uart_tx_flow_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .txd           (txd),
    .rts           (rts),
    .tx_rdy        (tx_rdy),
    .wr_valid      (wr_valid),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .mode_cts_gate (mode_cts_gate),
    .mode_auto_rts (mode_auto_rts),
    .cts_s         (cts_s),
    .idle_w        (idle_w),
    .brk_w         (brk_w)
);

// File: tb/uart_tx_flow_tb_top.sv
module uart_tx_flow_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic       mode_cts_gate = 1'b0;
    logic       mode_auto_rts = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cts = 1'b0;
    logic       txd, rts, tx_rdy;

    int n_chk = 0;
    int n_fail = 0;
    int frames_seen = 0;
    bit mon_en = 1'b1;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    uart_tx_flow dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .mode_cts_gate(mode_cts_gate), .mode_auto_rts(mode_auto_rts),
        .wr_valid(wr_valid), .wr_data(wr_data), .cts(cts),
        .txd(txd), .rts(rts), .tx_rdy(tx_rdy)
    );

    // 16x tick: one pulse every 4 clocks, so one bit is 64 clocks
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        while (!tx_rdy) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        exp_q.push_back(b);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_fall();
        @(negedge clk);
        while (txd) @(negedge clk);
    endtask

    // monitor: decodes frames and compares with the scoreboard queue (R2)
    initial begin
        logic prev;
        logic [7:0] got;
        logic [7:0] exp;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_en && prev && !txd) begin
                repeat (30) @(negedge clk);
                check(txd == 1'b0, "R2 start bit", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (64) @(negedge clk);
                    got[i] = txd;
                end
                repeat (64) @(negedge clk);
                check(txd == 1'b1, "R2 stop bit", txd, 1);
                frames_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected frame", got, 0);
                end else begin
                    exp = exp_q.pop_front();
                    check(got == exp, "R2 frame data", got, exp);
                end
            end
            prev = txd;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int fs;
        int gap;
        bit stayed;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R1 txd idle", txd, 1);
        check(rts == 1'b0, "R1 rts negated", rts, 0);
        check(tx_rdy == 1'b1, "R1 tx_rdy", tx_rdy, 1);

        // R1 disabled after reset; R3 ready drops
        put_byte(8'h3C);
        check(tx_rdy == 1'b0, "R3 ready after write", tx_rdy, 0);
        stayed = 1'b1;
        repeat (1500) begin @(negedge clk); if (!txd) stayed = 1'b0; end
        check(stayed, "R1 nothing sent while disabled", stayed, 1);
        // R3 write while not ready is ignored (scoreboard would see 99)
        wr_valid = 1'b1; wr_data = 8'h99;
        @(negedge clk);
        wr_valid = 1'b0;

        // R4 enable; R2 frames
        send_cmd(3'd1);
        repeat (3) @(negedge clk);
        check(tx_rdy == 1'b1, "R3 ready after move to shifter", tx_rdy, 1);
        put_byte(8'h55);
        put_byte(8'h00);
        put_byte(8'hFF);
        put_byte(8'hA3);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (200) @(negedge clk);
        check(frames_seen == 5, "R2 frame count", frames_seen, 5);

        // R5 gating holds the start
        mode_cts_gate = 1'b1; cts = 1'b0;
        fs = frames_seen;
        put_byte(8'h81);
        stayed = 1'b1;
        repeat (1500) begin @(negedge clk); if (!txd) stayed = 1'b0; end
        check(stayed, "R5 held while cts low", stayed, 1);
        cts = 1'b1;
        repeat (800) @(negedge clk);
        check(frames_seen == fs + 1, "R5 sent after cts high", frames_seen, fs + 1);
        // R5 cts drop inside a character
        put_byte(8'h7E);
        wait_fall();
        repeat (100) @(negedge clk);
        cts = 1'b0;
        repeat (700) @(negedge clk);
        check(exp_q.size() == 0, "R5 character completes", exp_q.size(), 0);
        // R5 no gating: cts ignored
        mode_cts_gate = 1'b0;
        put_byte(8'h42);
        repeat (800) @(negedge clk);
        check(exp_q.size() == 0, "R5 cts ignored without gating", exp_q.size(), 0);

        // R6 break with cts low and gating on
        mode_cts_gate = 1'b1; cts = 1'b0;
        mon_en = 1'b0;
        send_cmd(3'd3);
        repeat (3) @(negedge clk);
        check(txd == 1'b0, "R6 break low", txd, 0);
        stayed = 1'b1;
        repeat (500) begin @(negedge clk); if (txd) stayed = 1'b0; end
        check(stayed, "R6 break held low", stayed, 1);
        put_byte(8'h5A);
        cts = 1'b1;
        send_cmd(3'd4);
        while (!txd) @(negedge clk);
        mon_en = 1'b1;
        gap = 0;
        while (txd && gap < 400) begin @(negedge clk); gap++; end
        check(gap >= 60 && gap <= 70, "R6 gap after break", gap, 64);
        repeat (800) @(negedge clk);
        check(exp_q.size() == 0, "R6 queued byte after break", exp_q.size(), 0);

        // R7 deferred disable
        mode_cts_gate = 1'b0;
        fs = frames_seen;
        put_byte(8'h11);
        wait_fall();
        put_byte(8'h22);
        send_cmd(3'd2);
        repeat (1500) @(negedge clk);
        check(frames_seen == fs + 2, "R7 shifting and held bytes sent", frames_seen, fs + 2);
        fs = frames_seen;
        put_byte(8'h33);
        repeat (1500) @(negedge clk);
        check(frames_seen == fs, "R7 disabled holds byte", frames_seen, fs);
        send_cmd(3'd1);
        repeat (800) @(negedge clk);
        check(exp_q.size() == 0, "R4 enable resumes", exp_q.size(), 0);

        // R8 set, R9 automatic negation
        send_cmd(3'd5);
        check(rts == 1'b1, "R8 rts set", rts, 1);
        mode_auto_rts = 1'b1;
        put_byte(8'h6B);
        wait_fall();
        send_cmd(3'd2);
        repeat (666) @(negedge clk);
        check(rts == 1'b1, "R9 rts held during last bit-time", rts, 1);
        repeat (50) @(negedge clk);
        check(rts == 1'b0, "R9 rts negated one bit after stop", rts, 0);
        fs = frames_seen;
        put_byte(8'h19);
        repeat (1500) @(negedge clk);
        check(frames_seen == fs, "R9 transmitter left disabled", frames_seen, fs);
        send_cmd(3'd5);
        send_cmd(3'd1);
        repeat (800) @(negedge clk);
        check(exp_q.size() == 0, "R9 resend after set and enable", exp_q.size(), 0);
        check(rts == 1'b1, "R9 rts kept while enabled", rts, 1);
        send_cmd(3'd6);
        check(rts == 1'b0, "R8 rts clear", rts, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule